// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting channel for a programmable interval timer. Software (through a separate front end that handles register decoding and byte ordering) hands the channel a three-bit mode code, a decimal/binary flag and a 16-bit start value with a one-cycle write strobe. From then on the channel counts on every clock edge, qualified or triggered by a gate input. It drives an output waveform whose shape depends on the mode, the live count, and a flag that tells software when a written value has not yet reached the counting register.

Six waveforms are supported: a level that rises at terminal count, a gate-fired one-shot, a periodic one-clock low pulse, a square wave built by stepping the counter down by two, and two one-clock strobes, one started by the write and one by the gate. The count can run as plain binary or as four decimal digits. A start value of zero means the full range.

The controller is a state machine with six states. IDLE is the state after reset. XFER is the one-cycle copy of the written value into the counter. WAIT means the value is held until a gate trigger. RUN means counting. STROBE is the single low output cycle of the strobe modes. HOLD means terminal count has been reached and the channel is waiting. The transitions are:
- program: any state to XFER, or to WAIT in modes 001 and 101.
- transfer: XFER to RUN.
- trigger: WAIT, RUN or HOLD to RUN in modes 001 and 101.
- terminal: RUN to HOLD in modes 000 and 001, or RUN to STROBE in modes 100 and 101.
- release: STROBE to HOLD.

Modes 010 and 011 stay in RUN and reload themselves.

Top module: `ivc_channel`

## Requirements
- R1: After reset, out_o is 1, count_o is 0 and null_o is 0.
- R2: Mode code 000 (terminal level): out_o is 0 after the write. The written value N is in count_o one clock after the write edge. The count then drops by one per enabled clock. out_o goes to 1 on the edge where count_o reaches 0 and stays 1, with the count held at 0, until the next write.
- R3: Mode code 100 (write-started strobe): out_o stays 1 while counting. It goes to 0 for exactly one clock on the edge where the count reaches 0, then returns to 1 and the channel holds.
- R4: Mode code 010 (rate): the period is N clocks. out_o goes to 0 on the edge where the count reaches 1. On the following edge the counter reloads and out_o returns to 1.
- R5: Mode code 011 (square) with an even N: the counter steps down by 2 per clock. out_o toggles and the counter reloads each time the count reaches 0, giving N/2 clocks high and N/2 clocks low.
- R6: Mode code 011 with an odd N: the first step of the high half is one and the rest are two, so out_o is high for (N+1)/2 clocks. The low half starts from N-1 and lasts (N-1)/2 clocks.
- R7: When the decimal flag is 1, each 4-bit digit of the count runs 9 down to 0 with a borrow into the next digit, for example 0x0010 steps to 0x0009. In mode 011 it steps to 0x0008.
- R8: In modes 000, 010, 011 and 100, gate_i at 0 freezes the count. In modes 010 and 011 it also forces out_o to 1. A 0-to-1 gate transition in modes 010 and 011 reloads the count and drives out_o to 1.
- R9: A start value of 0 counts as the full range: the first decrement gives 0xFFFF in binary and 0x9999 in decimal.
- R10: Mode code 001 (one-shot): a 0-to-1 gate transition loads N and drives out_o to 0. out_o returns to 1 when the count reaches 0. A later transition retriggers. A value written during the shot waits for the next trigger.
- R11: Mode code 101 (gate-started strobe): a 0-to-1 gate transition loads N with out_o at 1. out_o is 0 for one clock at count 0 and then returns to 1.
- R12: null_o is 1 after every write edge. It returns to 0 on the edge that copies the written value into the counter.
- R13: In modes 000 and 100, a write restarts counting at once. In modes 001, 010, 011 and 101, a write that keeps the same mode and decimal flag while the channel is active leaves the running count untouched until the next period end or trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Mode code, sampled on a write (110 and 111 alias to 010 and 011) |
| bcd_i | input | 1 | 1 = four decimal digits, 0 = binary, sampled on a write |
| load_i | input | 1 | One-cycle write strobe for the start value |
| count_i | input | 16 | Start value |
| gate_i | input | 1 | Gate: level enable or trigger, depending on the mode |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Live count |
| null_o | output | 1 | Written value not yet in the counter |

## Verification
A wrong state shows at the ports within one or two clocks. A missed XFER leaves null_o high and count_o unchanged on the edge after a write. A skipped STROBE or a lost reload shows as an out_o level that lasts one clock too long, or a count that keeps falling past the expected reload. The square-wave halves and the rate period are measured edge by edge, so an off-by-one in the half lengths or in the parity of the first step appears as a count or level mismatch at the exact edge where a toggle was due.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [2:0] {
        MD_TERMINAL    = 3'd0,
        MD_ONESHOT     = 3'd1,
        MD_RATE        = 3'd2,
        MD_SQUARE      = 3'd3,
        MD_SOFT_STROBE = 3'd4,
        MD_HARD_STROBE = 3'd5
    } ivc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_WAIT,
        ST_RUN,
        ST_STROBE,
        ST_HOLD
    } ivc_state_e;
endpackage

// File: rtl/ivc_decr.sv
module ivc_decr #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             bcd_i,
    input  logic             two_i,
    output logic [WIDTH-1:0] val_o
);
    localparam int DIGITS = WIDTH / 4;

    logic [WIDTH-1:0] bin_res;
    logic [WIDTH-1:0] dec_res;
    logic [DIGITS:0]  brw;

    assign bin_res = val_i - (two_i ? WIDTH'(2) : WIDTH'(1));
    assign brw[0]  = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [1:0] amt;
        logic [4:0] diff;
        assign amt  = (g == 0) ? (two_i ? 2'd2 : 2'd1) : {1'b0, brw[g]};
        assign diff = {1'b0, val_i[4*g +: 4]} - {3'b000, amt};
        assign brw[g+1] = diff[4];
        assign dec_res[4*g +: 4] = diff[4] ? 4'(diff + 5'd10) : diff[3:0];
    end

    assign val_o = bcd_i ? dec_res : bin_res;
endmodule

// File: rtl/ivc_gate_sense.sv
module ivc_gate_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ivc_channel.sv
module ivc_channel
    import ivc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             bcd_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic             gate_i,
    output logic             out_o,
    output logic [WIDTH-1:0] count_o,
    output logic             null_o
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    ivc_state_e       state_q, state_d;
    ivc_mode_e        mode_r, mode_n;
    logic             bcd_r;
    logic [WIDTH-1:0] reload_r;
    logic [WIDTH-1:0] cnt_q, cnt_d, cnt_dec;
    logic             out_q, out_d, null_q, null_d;
    logic             gate_rise, prog, trig, gated_mode, sq_two;

    always_comb begin
        unique case (mode_i)
            3'd6:    mode_n = MD_RATE;
            3'd7:    mode_n = MD_SQUARE;
            default: mode_n = ivc_mode_e'(mode_i);
        endcase
    end

    ivc_gate_sense u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise_o (gate_rise)
    );

    assign sq_two = (mode_r == MD_SQUARE) && !cnt_q[0];

    ivc_decr #(.WIDTH(WIDTH)) u_decr (
        .val_i (cnt_q),
        .bcd_i (bcd_r),
        .two_i (sq_two),
        .val_o (cnt_dec)
    );

    assign prog = load_i && (state_q == ST_IDLE || mode_n != mode_r || bcd_i != bcd_r
                             || mode_n == MD_TERMINAL || mode_n == MD_SOFT_STROBE);
    assign trig = gate_rise && (mode_r == MD_ONESHOT || mode_r == MD_HARD_STROBE);
    assign gated_mode = (mode_r == MD_RATE || mode_r == MD_SQUARE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_r <= '0;
            mode_r   <= MD_TERMINAL;
            bcd_r    <= 1'b0;
        end else begin
            if (load_i) reload_r <= count_i;
            if (prog) begin
                mode_r <= mode_n;
                bcd_r  <= bcd_i;
            end
        end
    end

    // Next-state and next-output logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        null_d  = null_q | load_i;
        if (prog) begin
            out_d   = (mode_n != MD_TERMINAL);
            state_d = (mode_n == MD_ONESHOT || mode_n == MD_HARD_STROBE) ? ST_WAIT : ST_XFER;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_XFER: begin
                    cnt_d   = reload_r;
                    null_d  = load_i;
                    state_d = ST_RUN;
                end
                ST_WAIT, ST_HOLD: begin
                    if (trig) begin
                        cnt_d   = reload_r;
                        null_d  = load_i;
                        out_d   = (mode_r != MD_ONESHOT);
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (trig) begin
                        cnt_d  = reload_r;
                        null_d = load_i;
                        out_d  = (mode_r != MD_ONESHOT);
                    end else if (gated_mode && gate_rise) begin
                        cnt_d  = reload_r;
                        null_d = load_i;
                        out_d  = 1'b1;
                    end else if (gated_mode && !gate_i) begin
                        out_d = 1'b1;
                    end else if (gate_i || mode_r == MD_ONESHOT || mode_r == MD_HARD_STROBE) begin
                        cnt_d = cnt_dec;
                        unique case (mode_r)
                            MD_TERMINAL, MD_ONESHOT: begin
                                if (cnt_dec == '0) begin
                                    out_d   = 1'b1;
                                    state_d = ST_HOLD;
                                end
                            end
                            MD_RATE: begin
                                if (!out_q) begin
                                    cnt_d  = reload_r;
                                    null_d = load_i;
                                    out_d  = 1'b1;
                                end else if (cnt_dec == ONE) begin
                                    out_d = 1'b0;
                                end
                            end
                            MD_SQUARE: begin
                                if (cnt_dec == '0) begin
                                    out_d  = ~out_q;
                                    cnt_d  = out_q ? {reload_r[WIDTH-1:1], 1'b0} : reload_r;
                                    null_d = load_i;
                                end
                            end
                            MD_SOFT_STROBE, MD_HARD_STROBE: begin
                                if (cnt_dec == '0) begin
                                    out_d   = 1'b0;
                                    state_d = ST_STROBE;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_STROBE: begin
                    out_d   = 1'b1;
                    state_d = ST_HOLD;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b1;
            null_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            out_q  <= out_d;
            null_q <= null_d;
        end
    end

    assign out_o   = out_q;
    assign count_o = cnt_q;
    assign null_o  = null_q;

    a_r12_null_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> null_o);

    a_r4_rate_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == MD_RATE && !out_o && !load_i) |=> out_o);

    a_r3_soft_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == MD_SOFT_STROBE && !out_o && !load_i) |=> out_o);

    a_r11_hard_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == MD_HARD_STROBE && !out_o && !load_i) |=> out_o);

    a_r2_terminal_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == MD_TERMINAL && out_o && !load_i) |=> (out_o && $stable(count_o)));

    a_r6_square_low_even: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == MD_SQUARE && state_q == ST_RUN && !out_o) |-> !count_o[0]);
endmodule

// File: tb/ivc_channel_test.sv
`timescale 1ns/1ps
module ivc_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        bcd_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] count_i = '0;
    logic        gate_i = 1'b0;
    logic        out_o;
    logic [15:0] count_o;
    logic        null_o;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ivc_channel uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bcd_i(bcd_i), .load_i(load_i),
        .count_i(count_i), .gate_i(gate_i), .out_o(out_o), .count_o(count_o), .null_o(null_o)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        bcd;
        logic [15:0] cnt;
        logic        gate;
        logic [7:0]  k;
        logic        eout;
        logic [15:0] ecnt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 16'd5,      1'b1, 8'd5, 1'b0, 16'd1},      // R2
        '{3'd0, 1'b0, 16'd5,      1'b1, 8'd6, 1'b1, 16'd0},      // R2
        '{3'd0, 1'b0, 16'd5,      1'b1, 8'd9, 1'b1, 16'd0},      // R2
        '{3'd0, 1'b0, 16'd5,      1'b0, 8'd4, 1'b0, 16'd5},      // R8
        '{3'd0, 1'b1, 16'h0010,   1'b1, 8'd2, 1'b0, 16'h0009},   // R7
        '{3'd0, 1'b1, 16'h0000,   1'b1, 8'd2, 1'b0, 16'h9999},   // R9
        '{3'd0, 1'b0, 16'h0000,   1'b1, 8'd2, 1'b0, 16'hFFFF},   // R9
        '{3'd2, 1'b0, 16'd4,      1'b1, 8'd4, 1'b0, 16'd1},      // R4
        '{3'd2, 1'b0, 16'd4,      1'b1, 8'd5, 1'b1, 16'd4},      // R4
        '{3'd2, 1'b0, 16'd4,      1'b1, 8'd8, 1'b0, 16'd1},      // R4
        '{3'd3, 1'b0, 16'd6,      1'b1, 8'd3, 1'b1, 16'd2},      // R5
        '{3'd3, 1'b0, 16'd6,      1'b1, 8'd4, 1'b0, 16'd6},      // R5
        '{3'd3, 1'b0, 16'd6,      1'b1, 8'd7, 1'b1, 16'd6},      // R5
        '{3'd3, 1'b0, 16'd5,      1'b1, 8'd4, 1'b0, 16'd4},      // R6
        '{3'd3, 1'b0, 16'd5,      1'b1, 8'd6, 1'b1, 16'd5},      // R6
        '{3'd4, 1'b0, 16'd3,      1'b1, 8'd4, 1'b0, 16'd0},      // R3
        '{3'd4, 1'b0, 16'd3,      1'b1, 8'd5, 1'b1, 16'd0},      // R3
        '{3'd3, 1'b1, 16'h0010,   1'b1, 8'd2, 1'b1, 16'h0008}    // R7
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        load_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write(input logic [2:0] m, input logic b, input logic [15:0] v);
        mode_i  = m;
        bcd_i   = b;
        count_i = v;
        load_i  = 1'b1;
        @(negedge clk);
        load_i  = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 out", {15'd0, out_o}, 16'd1);
        chk("R1 count", count_o, 16'd0);
        chk("R1 null", {15'd0, null_o}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            gate_i = VECS[i].gate;
            write(VECS[i].mode, VECS[i].bcd, VECS[i].cnt);
            step(int'(VECS[i].k));
            chk($sformatf("vec%0d count", i), count_o, VECS[i].ecnt);
            chk($sformatf("vec%0d out", i), {15'd0, out_o}, {15'd0, VECS[i].eout});
        end

        // R10 one-shot with pending rewrite, R12 null flag
        do_reset();
        gate_i = 1'b0;
        write(3'd1, 1'b0, 16'd3);
        chk("R12 null set", {15'd0, null_o}, 16'd1);
        chk("R10 idle out", {15'd0, out_o}, 16'd1);
        gate_i = 1'b1;
        step(1);
        chk("R10 trig count", count_o, 16'd3);
        chk("R10 trig out", {15'd0, out_o}, 16'd0);
        chk("R12 null clear", {15'd0, null_o}, 16'd0);
        step(1);
        write(3'd1, 1'b0, 16'd7);
        chk("R13 oneshot untouched", count_o, 16'd1);
        chk("R12 null pending", {15'd0, null_o}, 16'd1);
        step(1);
        chk("R10 end out", {15'd0, out_o}, 16'd1);
        chk("R10 end count", count_o, 16'd0);
        gate_i = 1'b0;
        step(1);
        gate_i = 1'b1;
        step(1);
        chk("R10 retrig count", count_o, 16'd7);
        chk("R10 retrig out", {15'd0, out_o}, 16'd0);

        // R11 gate-started strobe
        do_reset();
        gate_i = 1'b0;
        write(3'd5, 1'b0, 16'd2);
        gate_i = 1'b1;
        step(1);
        chk("R11 start count", count_o, 16'd2);
        chk("R11 start out", {15'd0, out_o}, 16'd1);
        step(2);
        chk("R11 strobe low", {15'd0, out_o}, 16'd0);
        step(1);
        chk("R11 strobe high", {15'd0, out_o}, 16'd1);

        // R13 terminal-mode rewrite restarts
        do_reset();
        gate_i = 1'b1;
        write(3'd0, 1'b0, 16'd10);
        step(4);
        chk("R2 mid count", count_o, 16'd7);
        write(3'd0, 1'b0, 16'd3);
        chk("R13 restart hold", count_o, 16'd7);
        chk("R12 restart null", {15'd0, null_o}, 16'd1);
        step(1);
        chk("R13 restart count", count_o, 16'd3);

        // R4/R13 rate rewrite mid-period
        do_reset();
        gate_i = 1'b1;
        write(3'd2, 1'b0, 16'd4);
        step(2);
        write(3'd2, 1'b0, 16'd6);
        chk("R13 rate untouched", count_o, 16'd2);
        step(2);
        chk("R4 new period count", count_o, 16'd6);
        chk("R12 rate null clear", {15'd0, null_o}, 16'd0);

        // R8 gate suspend and restart in rate mode
        do_reset();
        gate_i = 1'b1;
        write(3'd2, 1'b0, 16'd5);
        step(2);
        gate_i = 1'b0;
        step(2);
        chk("R8 frozen count", count_o, 16'd4);
        chk("R8 forced high", {15'd0, out_o}, 16'd1);
        gate_i = 1'b1;
        step(1);
        chk("R8 restart count", count_o, 16'd5);
        step(1);
        chk("R8 running again", count_o, 16'd4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule